// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Controller

This block connects a simple internal request port to an external asynchronous static memory such as an SRAM or a NOR flash. A requester presents a request with a direction bit, an address and write data. The block registers them on acceptance and runs one access on the memory pins: an address setup phase, then a data phase, then an optional bus turnaround gap. It drives an active-low chip select, output enable and write enable, the address bus and a tri-state data bus. The length of each phase is set in whole clock cycles.

Reads and writes use separate timing sets, each with its own setup, data and turnaround fields. The timing fields of the chosen set are latched at acceptance. A new request that waits during the turnaround gap is started the moment the gap ends. Read data is captured at the close of the read data phase, and a one-cycle completion pulse follows for both reads and writes.

Top module: `sram_timing_ctrl`

## Requirements
- R1: During and right after reset, mem_cs_n, mem_oe_n and mem_we_n are high, done is low and req_ready is high.
- R2: The address setup phase has chip select low and both strobes high. It lasts the selected setup field plus 1 cycles.
- R3: The read data phase lasts the read data field plus 3 cycles, and mem_oe_n is low for exactly those cycles with mem_we_n high.
- R4: The write data phase lasts the write data field plus 1 cycles, and mem_we_n is low for exactly those cycles with mem_oe_n high.
- R5: A data field of 0 is treated as 1, so a read data phase lasts 4 cycles and a write data phase lasts 2 cycles.
- R6: Chip select stays low without a break across both phases. mem_addr carries the address registered at acceptance for every cycle chip select is low, even if req_addr changes afterwards.
- R7: During a write access the block drives the write data registered at acceptance onto mem_dq in every cycle that chip select is low. It releases the bus during reads and when idle.
- R8: rd_data takes the value on mem_dq in the last read data cycle. done is high for the single cycle after chip select rises, and never while chip select is low.
- R9: When a request is already waiting as an access ends, chip select stays high for exactly max(T,1) cycles before the next access. T is the turnaround field of the set used by the access that just ended.
- R10: A read uses only the read timing fields and a write uses only the write timing fields. Changes to any timing input after acceptance do not affect the access in progress.
- R11: req_ready is low while chip select is low. A request held during the turnaround gap is accepted in the gap's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |
| rd_setup | input | SETUP_W | Read address setup field |
| rd_dphase | input | DPH_W | Read data phase field |
| rd_turn | input | TURN_W | Read turnaround field |
| wr_setup | input | SETUP_W | Write address setup field |
| wr_dphase | input | DPH_W | Write data phase field |
| wr_turn | input | TURN_W | Write turnaround field |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq | inout | DATA_W | Memory data bus |

## Verification
The bench counts setup and data cycles on the pins for every access, including a data field of zero and the largest field values. A design that lost the asymmetric +3/+1 offsets, or that let a zero slip through, would show data phases one or two cycles off. Back-to-back requests with turnaround values of 0 and non-zero check the gap against the field of the finished access and not the next one. An off-by-one in the gap counter, or reading the wrong timing set, shows up as a gap of the wrong length. After acceptance the bench changes the address, the write data and all timing inputs, so a design that does not register them would move the bus or the phase lengths during the access.

// File: rtl/sram_tc_pkg.sv
// Shared types for the static memory timing controller.
package sram_tc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2,
        ST_TURN  = 2'd3
    } tc_state_t;
endpackage

// File: rtl/sram_tc_fsm.sv
// Phase sequencer: accepts a request, latches the timing set for its
// direction and counts the setup, data and turnaround phases.
// Assumes the timing inputs are valid whenever req_valid is high.
module sram_tc_fsm #(
    parameter int SETUP_W = 4,
    parameter int DPH_W   = 8,
    parameter int TURN_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SETUP_W-1:0] rd_setup,
    input  logic [DPH_W-1:0]   rd_dphase,
    input  logic [TURN_W-1:0]  rd_turn,
    input  logic [SETUP_W-1:0] wr_setup,
    input  logic [DPH_W-1:0]   wr_dphase,
    input  logic [TURN_W-1:0]  wr_turn,
    output logic               ready,
    output logic               accept,
    output logic               last_rd,
    output logic               drive_dq,
    output logic               done,
    output logic               cs_n,
    output logic               oe_n,
    output logic               we_n
);
    import sram_tc_pkg::*;

    localparam int W_A   = (SETUP_W > DPH_W + 1) ? SETUP_W : DPH_W + 1;
    localparam int CNT_W = (W_A > TURN_W) ? W_A : TURN_W;

    tc_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   dlen_q;
    logic [TURN_W-1:0]  turn_q;
    logic               wr_q;

    logic [SETUP_W-1:0] sel_setup;
    logic [DPH_W-1:0]   sel_dph;
    logic [TURN_W-1:0]  sel_turn;
    logic [CNT_W-1:0]   dph_eff;
    logic [CNT_W-1:0]   sel_dlen;

    // Pick the timing set of the incoming request and derive its data count.
    always_comb begin
        sel_setup = req_write ? wr_setup  : rd_setup;
        sel_dph   = req_write ? wr_dphase : rd_dphase;
        sel_turn  = req_write ? wr_turn   : rd_turn;
        dph_eff   = (sel_dph == '0) ? CNT_W'(1) : CNT_W'(sel_dph);
        sel_dlen  = req_write ? dph_eff : dph_eff + CNT_W'(2);
    end

    assign ready  = (state == ST_IDLE) || (state == ST_TURN && cnt == '0);
    assign accept = ready && req_valid;

    // Pin strobes decoded from the registered phase.
    assign cs_n     = !(state == ST_SETUP || state == ST_DATA);
    assign oe_n     = !(state == ST_DATA && !wr_q);
    assign we_n     = !(state == ST_DATA && wr_q);
    assign drive_dq = wr_q && !cs_n;
    assign last_rd  = (state == ST_DATA) && (cnt == '0) && !wr_q;

    // Phase state, down-counter and latched timing of the current access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            dlen_q <= '0;
            turn_q <= '0;
            wr_q   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE, ST_TURN: begin
                    if (accept) begin
                        state  <= ST_SETUP;
                        cnt    <= CNT_W'(sel_setup);
                        dlen_q <= sel_dlen;
                        turn_q <= sel_turn;
                        wr_q   <= req_write;
                    end else if (state == ST_TURN) begin
                        if (cnt == '0) state <= ST_IDLE;
                        else           cnt   <= cnt - 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_DATA;
                        cnt   <= dlen_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == '0) begin
                        done <= 1'b1;
                        if (turn_q == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_TURN;
                            cnt   <= CNT_W'(turn_q) - 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_tc_datapath.sv
// Request datapath: registers address and write data at acceptance and
// captures read data on the last read data cycle. Assumes accept and
// capture are never high in the same cycle.
module sram_tc_datapath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rd_data
);
    // Hold the request fields for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the memory bus at the close of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= dq_in;
    end
endmodule

// File: rtl/sram_timing_ctrl.sv
// Top level: asynchronous static memory timing controller. Joins the
// phase sequencer and the datapath and owns the tri-state data bus.
module sram_timing_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int SETUP_W = 4,
    parameter int DPH_W   = 8,
    parameter int TURN_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [SETUP_W-1:0] rd_setup,
    input  logic [DPH_W-1:0]   rd_dphase,
    input  logic [TURN_W-1:0]  rd_turn,
    input  logic [SETUP_W-1:0] wr_setup,
    input  logic [DPH_W-1:0]   wr_dphase,
    input  logic [TURN_W-1:0]  wr_turn,
    output logic               mem_cs_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [ADDR_W-1:0]  mem_addr,
    inout  wire  [DATA_W-1:0]  mem_dq
);
    logic              accept;
    logic              last_rd;
    logic              drive_dq;
    logic [DATA_W-1:0] wdata_q;

    sram_tc_fsm #(
        .SETUP_W(SETUP_W), .DPH_W(DPH_W), .TURN_W(TURN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .rd_setup(rd_setup), .rd_dphase(rd_dphase), .rd_turn(rd_turn),
        .wr_setup(wr_setup), .wr_dphase(wr_dphase), .wr_turn(wr_turn),
        .ready(req_ready), .accept(accept), .last_rd(last_rd),
        .drive_dq(drive_dq), .done(done),
        .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n)
    );

    sram_tc_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dp (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .capture(last_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq),
        .addr_q(mem_addr), .wdata_q(wdata_q), .rd_data(rd_data)
    );

    // Drive the data bus only while a write holds chip select low.
    assign mem_dq = drive_dq ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_timing_chk.sv
// Protocol checker for the memory pins, bound to the top module.
module sram_timing_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              req_ready
);
    // R3
    oe_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);
    // R4
    we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));
    // R6
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));
    // R8
    done_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(mem_cs_n));
    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);
endmodule

bind sram_timing_ctrl sram_timing_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .done(done), .req_ready(req_ready)
);

// File: tb/sram_timing_ctrl_bench.sv
// Bench: directed corner cases plus seeded random accesses, measured at the pins.
module sram_timing_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SW = 4;
    localparam int PW = 8;
    localparam int TW = 4;
    localparam logic [DW-1:0] RD_KEY = 16'h5A3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, done;
    logic [DW-1:0] rd_data;
    logic [SW-1:0] rd_setup = '0, wr_setup = '0;
    logic [PW-1:0] rd_dphase = '0, wr_dphase = '0;
    logic [TW-1:0] rd_turn = '0, wr_turn = '0;
    logic mem_cs_n, mem_oe_n, mem_we_n;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;
    logic [DW-1:0] model_word;

    int n_checks = 0;
    int n_fails = 0;
    int last_turn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: returns address xor key while output enable is low.
    assign model_word = DW'(mem_addr) ^ RD_KEY;
    assign mem_dq = mem_oe_n ? {DW{1'bz}} : model_word;

    sram_timing_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_W(SW), .DPH_W(PW), .TURN_W(TW)
    ) u_sram_timing_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data),
        .rd_setup(rd_setup), .rd_dphase(rd_dphase), .rd_turn(rd_turn),
        .wr_setup(wr_setup), .wr_dphase(wr_dphase), .wr_turn(wr_turn),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    function automatic int exp_setup(int su);
        return su + 1;
    endfunction

    function automatic int exp_data(bit w, int d);
        int de = (d == 0) ? 1 : d;
        return w ? de + 1 : de + 3;
    endfunction

    function automatic int exp_gap(int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // One access; starts and ends at a falling edge, returning in the
    // first cycle after chip select rises.
    task automatic run_access(bit w, logic [AW-1:0] a, logic [DW-1:0] wd,
                              int su, int d, int t, bit b2b);
        int gap = 1;
        int su_cnt = 0, dt_cnt = 0, bad = 0, abad = 0, dqbad = 0, dbad = 0, rbad = 0;
        if (w) begin
            wr_setup = SW'(su); wr_dphase = PW'(d); wr_turn = TW'(t);
            rd_setup = SW'($urandom); rd_dphase = PW'($urandom); rd_turn = TW'($urandom);
        end else begin
            rd_setup = SW'(su); rd_dphase = PW'(d); rd_turn = TW'(t);
            wr_setup = SW'($urandom); wr_dphase = PW'($urandom); wr_turn = TW'($urandom);
        end
        req_write = w; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        while (mem_cs_n) begin
            gap++;
            @(negedge clk);
        end
        // R9 R11: a waiting request starts exactly when the gap expires
        if (b2b) chk(gap == exp_gap(last_turn), "R9 turnaround gap", gap, exp_gap(last_turn));
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~wd;
        rd_setup = SW'($urandom); rd_dphase = PW'($urandom); rd_turn = TW'($urandom);
        wr_setup = SW'($urandom); wr_dphase = PW'($urandom); wr_turn = TW'($urandom);
        while (!mem_cs_n) begin
            if (mem_oe_n && mem_we_n) begin
                if (dt_cnt > 0) bad++; else su_cnt++;
            end else if (w ? (!mem_we_n && mem_oe_n) : (!mem_oe_n && mem_we_n)) begin
                dt_cnt++;
            end else begin
                bad++;
            end
            if (mem_addr != a) abad++;
            if (w && mem_dq !== wd) dqbad++;
            if (done) dbad++;
            if (req_ready) rbad++;
            @(negedge clk);
        end
        chk(su_cnt == exp_setup(su), "R2 setup length", su_cnt, exp_setup(su));
        if (w) chk(dt_cnt == exp_data(1, d), "R4 write data length", dt_cnt, exp_data(1, d));
        else   chk(dt_cnt == exp_data(0, d), "R3 read data length", dt_cnt, exp_data(0, d));
        if (d == 0) chk(dt_cnt == exp_data(w, 1), "R5 zero data field", dt_cnt, exp_data(w, 1));
        chk(bad == 0, "R10 strobe pattern for direction", bad, 0);
        chk(abad == 0, "R6 registered address on bus", abad, 0);
        if (w) chk(dqbad == 0, "R7 write data driven", dqbad, 0);
        chk(dbad == 0, "R8 no done while selected", dbad, 0);
        chk(rbad == 0, "R11 not ready while selected", rbad, 0);
        chk(done == 1'b1, "R8 done after access", int'(done), 1);
        if (!w) chk(rd_data == (DW'(a) ^ RD_KEY), "R8 read capture",
                    int'(rd_data), int'(DW'(a) ^ RD_KEY));
        last_turn = t;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        int seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
            int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);
        chk(!done && req_ready, "R1 done low, ready high", int'({done, req_ready}), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && !done && req_ready, "R1 idle after reset",
            int'({mem_cs_n, done, req_ready}), 5);

        // Directed corners: zero fields (R5), extremes, back-to-back gaps (R9)
        run_access(1'b0, 16'h0001, 16'h0000, 0, 0, 0, 1'b0);
        run_access(1'b1, 16'h0002, 16'hBEEF, 0, 0, 0, 1'b1);
        run_access(1'b0, 16'h1234, 16'h0000, 3, 2, 4, 1'b1);
        run_access(1'b1, 16'hFFFF, 16'hA5A5, 15, 255, 15, 1'b1);
        run_access(1'b0, 16'h8000, 16'h0000, 15, 255, 1, 1'b1);
        run_access(1'b1, 16'h00F0, 16'h1357, 1, 1, 2, 1'b1);
        run_access(1'b0, 16'h0F0F, 16'h0000, 0, 1, 0, 1'b1);

        // Seeded random mix; back-to-back or with idle gaps
        for (int i = 0; i < 200; i++) begin
            bit b2b = 1'($urandom);
            if (!b2b) repeat (1 + ($urandom % 4)) @(negedge clk);
            run_access(1'($urandom), AW'($urandom), DW'($urandom),
                       int'($urandom % 4), int'($urandom % 6), int'($urandom % 5), b2b);
        end
        repeat (20) @(negedge clk);
        if (seed == -1) $display("seed note");
        summary();
        $finish;
    end
endmodule